// File: doc/BRIEF.md
# Task Context Register File

This block stores complete processor register contexts so that the core can switch tasks in hardware. Each slot holds one 256-bit snapshot of every core register. When a switch is requested, the core's live snapshot is written into the slot of the running task. The slot of the chosen task is then read back and presented to the core, all within three cycles. A return request picks its target from a per-task back-link. The back-link records which task last switched into the current one, so an invoked task can hand control back to its caller. Because the mode bits are part of the saved status extension byte, a switch can also move the core between operating modes.

A second path fills slots from memory. The core streams a 32-byte record into the block, one byte at a time, with the slot number given alongside the first byte. The record bytes map directly onto the snapshot word, and multi-byte fields are stored low byte first. A record that completes while a switch is in flight is held and written once the switch has done its read.

Top module: `tcx_task_file`

## Requirements
- R1: After reset, `cur_task_o` is 0 and `ctx_load_o` is 0.
- R2: An operation is accepted when `op_valid_i` is high while the block is idle. Call the accept edge E0. `ctx_load_o` stays low in the cycle after E0 and is high for exactly one cycle after the following edge. In that cycle `ctx_o` holds the target's saved snapshot and `cur_task_o` holds the target number.
- R3: On a switch (`op_kind_i`=0), the `core_ctx_i` value sampled at E0 is stored in the slot of the task that was running. A later switch back to that task returns exactly that value.
- R4: On a return (`op_kind_i`=1), the target is the back-link of the running task. A switch from task A to a different task B sets B's back-link to A, and a return leaves every back-link unchanged.
- R5: A switch to the running task delivers the snapshot given with the request unchanged on `ctx_o`. It leaves `cur_task_o` and all back-links unchanged.
- R6: A record is 32 bytes on `rec_byte_i`, with `rec_first_i` marking byte 0 and `rec_task_i` sampled with byte 0. Byte k becomes snapshot bits [8k+7:8k]. The fields are: code segment in bytes 0-3, data segment 4-7, PC 8-10, accumulator 11-14, X 15-18, Y 19-22, stack pointer 23-26, status 27, status extension 28, data bank 29, and direct page 30-31, each with its low byte first.
- R7: `op_valid_i` is ignored while an operation is in progress. It neither changes the target of the running operation nor starts a new one.
- R8: A record whose last byte arrives on an accept edge does not disturb that switch, and it is still written to its slot.
- R9: All back-links reset to 0. A return from task 0 before any switch into it therefore acts as a switch of task 0 to itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Operation request |
| op_kind_i | input | 1 | 0 = switch to `op_task_i`, 1 = return to invoker |
| op_task_i | input | TASK_W | Target task for a switch |
| core_ctx_i | input | CTX_W | Live register snapshot of the core |
| rec_valid_i | input | 1 | Record byte valid |
| rec_first_i | input | 1 | Marks byte 0 of a record |
| rec_task_i | input | TASK_W | Destination slot, taken with byte 0 |
| rec_byte_i | input | 8 | Record byte |
| ctx_o | output | CTX_W | Snapshot to load into the core |
| ctx_load_o | output | 1 | One-cycle strobe: load `ctx_o` now |
| cur_task_o | output | TASK_W | Number of the running task |

## Verification
A record can finish on the same edge where a switch is accepted. That edge needs the single write port for two things: the save of the running task and the commit of the new record. The bench provokes this collision by lining up the 32nd record byte with a switch request to a different task. It checks that the switch returns the correct snapshot. It then switches into the record's slot and expects the record word bit for bit. A second overlap, request pulses held during the busy cycles, is judged by the target and task number that result.

// File: rtl/tcx_pkg.sv
package tcx_pkg;

   typedef enum logic {
      OP_SWITCH = 1'b0,
      OP_RETURN = 1'b1
   } tcx_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_DONE = 2'd2
   } tcx_state_e;

   // Snapshot layout: the first struct member sits at the top bits, so the
   // list runs from the last record byte down to record byte 0.
   typedef struct packed {
      logic [15:0] dpage;
      logic [7:0]  dbank;
      logic [7:0]  stat_ext;
      logic [7:0]  stat;
      logic [31:0] sptr;
      logic [31:0] yreg;
      logic [31:0] xreg;
      logic [31:0] acc;
      logic [23:0] pc;
      logic [31:0] dseg;
      logic [31:0] cseg;
   } tcx_ctx_t;

   localparam int unsigned CTX_BITS  = $bits(tcx_ctx_t);
   localparam int unsigned REC_BYTES = CTX_BITS / 8;

endpackage

// File: rtl/tcx_ctx_ram.sv
module tcx_ctx_ram #(
   parameter int unsigned DEPTH = 512,
   parameter int unsigned WIDTH = 256,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we_i,
   input  logic [AW-1:0]    wa_i,
   input  logic [WIDTH-1:0] wd_i,
   input  logic             re_i,
   input  logic [AW-1:0]    ra_i,
   output logic [WIDTH-1:0] rd_o
);

   logic [WIDTH-1:0] mem [DEPTH];

   // Old contents are returned when a read and a write hit one address.
   always_ff @(posedge clk) begin
      if (we_i) mem[wa_i] <= wd_i;
      if (re_i) rd_o <= mem[ra_i];
   end

endmodule

// File: rtl/tcx_link_file.sv
module tcx_link_file #(
   parameter int unsigned DEPTH = 512,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] wa_i,
   input  logic [AW-1:0] wd_i,
   input  logic [AW-1:0] ra_i,
   output logic [AW-1:0] rd_o
);

   logic [AW-1:0] link_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_link
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            link_q[g] <= '0;
         end else if (we_i && (wa_i == AW'(g))) begin
            link_q[g] <= wd_i;
         end
      end
   end

   assign rd_o = link_q[ra_i];

endmodule

// File: rtl/tcx_rec_asm.sv
module tcx_rec_asm #(
   parameter int unsigned BYTES  = 32,
   parameter int unsigned TASK_W = 9,
   localparam int unsigned W  = BYTES * 8,
   localparam int unsigned CW = (BYTES > 1) ? $clog2(BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic              first_i,
   input  logic [7:0]        byte_i,
   input  logic [TASK_W-1:0] task_i,
   output logic              done_o,
   output logic [W-1:0]      word_o,
   output logic [TASK_W-1:0] task_o
);

   localparam logic [CW-1:0] LAST = CW'(BYTES - 1);

   logic [CW-1:0]     cnt_q;
   logic [CW-1:0]     cnt_eff;
   logic [W-1:0]      shift_q;
   logic [TASK_W-1:0] task_q;

   if (BYTES < 2) begin : g_chk
      $error("tcx_rec_asm: a record needs at least two bytes");
   end

   assign cnt_eff = first_i ? '0 : cnt_q;
   assign task_o  = first_i ? task_i : task_q;
   // Bytes enter at the top and drift down, so byte 0 ends at the LSBs.
   assign word_o  = {byte_i, shift_q[W-1:8]};
   assign done_o  = valid_i && (cnt_eff == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         shift_q <= '0;
         task_q  <= '0;
      end else if (valid_i) begin
         shift_q <= word_o;
         cnt_q   <= done_o ? '0 : cnt_eff + 1'b1;
         if (first_i) task_q <= task_i;
      end
   end

endmodule

// File: rtl/tcx_task_file.sv
module tcx_task_file
   import tcx_pkg::*;
#(
   parameter int unsigned NUM_TASKS = 512,
   parameter int unsigned CTX_W     = 256,
   localparam int unsigned TASK_W   = $clog2(NUM_TASKS),
   localparam int unsigned RBYTES   = CTX_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid_i,
   input  logic              op_kind_i,
   input  logic [TASK_W-1:0] op_task_i,
   input  logic [CTX_W-1:0]  core_ctx_i,
   input  logic              rec_valid_i,
   input  logic              rec_first_i,
   input  logic [TASK_W-1:0] rec_task_i,
   input  logic [7:0]        rec_byte_i,
   output logic [CTX_W-1:0]  ctx_o,
   output logic              ctx_load_o,
   output logic [TASK_W-1:0] cur_task_o
);

   if (CTX_W != CTX_BITS) begin : g_chk_w
      $error("tcx_task_file: CTX_W must match the snapshot layout");
   end
   if (NUM_TASKS < 2) begin : g_chk_n
      $error("tcx_task_file: at least two task slots are required");
   end

   tcx_state_e        st_q;
   logic [TASK_W-1:0] cur_q, tgt_q, target, lk_cur;
   logic              accept, is_return;

   logic              rec_done;
   logic [CTX_W-1:0]  rec_word;
   logic [TASK_W-1:0] rec_task;
   logic              pend_q;
   logic [CTX_W-1:0]  pend_word_q;
   logic [TASK_W-1:0] pend_task_q;
   logic              commit;

   logic              ram_we;
   logic [TASK_W-1:0] ram_wa;
   logic [CTX_W-1:0]  ram_wd;
   logic              link_we;

   assign is_return = (tcx_op_e'(op_kind_i) == OP_RETURN);
   assign accept    = (st_q == ST_IDLE) && op_valid_i;
   assign target    = is_return ? lk_cur : op_task_i;

   // Record commit uses the write port whenever the save does not.
   assign commit  = pend_q && ((st_q == ST_DONE) || ((st_q == ST_IDLE) && !op_valid_i));
   assign ram_we  = accept || commit;
   assign ram_wa  = accept ? cur_q      : pend_task_q;
   assign ram_wd  = accept ? core_ctx_i : pend_word_q;
   assign link_we = accept && !is_return && (op_task_i != cur_q);

   tcx_ctx_ram #(.DEPTH(NUM_TASKS), .WIDTH(CTX_W)) u_ram (
      .clk  (clk),
      .we_i (ram_we),
      .wa_i (ram_wa),
      .wd_i (ram_wd),
      .re_i (st_q == ST_READ),
      .ra_i (tgt_q),
      .rd_o (ctx_o)
   );

   tcx_link_file #(.DEPTH(NUM_TASKS)) u_link (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (link_we),
      .wa_i  (op_task_i),
      .wd_i  (cur_q),
      .ra_i  (cur_q),
      .rd_o  (lk_cur)
   );

   tcx_rec_asm #(.BYTES(RBYTES), .TASK_W(TASK_W)) u_rec (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (rec_valid_i),
      .first_i (rec_first_i),
      .byte_i  (rec_byte_i),
      .task_i  (rec_task_i),
      .done_o  (rec_done),
      .word_o  (rec_word),
      .task_o  (rec_task)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cur_q <= '0;
         tgt_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (accept) begin
               tgt_q <= target;
               st_q  <= ST_READ;
            end
            ST_READ: begin
               cur_q <= tgt_q;
               st_q  <= ST_DONE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_word_q <= '0;
         pend_task_q <= '0;
      end else if (rec_done) begin
         pend_q      <= 1'b1;
         pend_word_q <= rec_word;
         pend_task_q <= rec_task;
      end else if (commit) begin
         pend_q <= 1'b0;
      end
   end

   assign ctx_load_o = (st_q == ST_DONE);
   assign cur_task_o = cur_q;

   // R2: the load strobe arrives two edges after acceptance
   a_r2_load_third_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> ##2 ctx_load_o);

   // R2: the strobe lasts one cycle
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_load_o |=> !ctx_load_o);

   // R5: a switch to itself hands back the snapshot just saved
   a_r5_self_keeps_ctx: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (target == cur_q)) |-> ##2 (ctx_o == $past(core_ctx_i, 2)));

   // R8: a finished record is never held longer than three cycles
   a_r8_commit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && $past(pend_q) && $past(pend_q, 2)) |-> commit);

   // R7: the running target is fixed until the operation ends
   a_r7_target_held: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_READ) |=> (cur_q == $past(tgt_q)));

endmodule

// File: tb/tcx_task_file_tb.sv
`timescale 1ns/1ps
module tcx_task_file_tb;

   localparam int N = 512;
   localparam int TW = 9;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           op_valid_i = 1'b0;
   logic           op_kind_i = 1'b0;
   logic [TW-1:0]  op_task_i = '0;
   logic [255:0]   core_ctx_i = '0;
   logic           rec_valid_i = 1'b0;
   logic           rec_first_i = 1'b0;
   logic [TW-1:0]  rec_task_i = '0;
   logic [7:0]     rec_byte_i = '0;
   logic [255:0]   ctx_o;
   logic           ctx_load_o;
   logic [TW-1:0]  cur_task_o;

   int errors = 0;
   int checks = 0;

   bit [255:0] m_ctx [N];
   int         m_link [N];
   int         m_cur = 0;

   int         p_kind, p_task, p_noisy;
   bit [255:0] p_snap;

   always #2 clk = ~clk;

   tcx_task_file u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_kind_i(op_kind_i),
      .op_task_i(op_task_i), .core_ctx_i(core_ctx_i), .rec_valid_i(rec_valid_i),
      .rec_first_i(rec_first_i), .rec_task_i(rec_task_i), .rec_byte_i(rec_byte_i),
      .ctx_o(ctx_o), .ctx_load_o(ctx_load_o), .cur_task_o(cur_task_o)
   );

   task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit [255:0] rnd256();
      bit [255:0] w;
      for (int i = 0; i < 8; i++) w[32*i +: 32] = $urandom();
      return w;
   endfunction

   function automatic int pick_target(int kind, int t);
      return (kind == 1) ? m_link[m_cur] : t;
   endfunction

   task automatic op_start(int kind, int t, bit [255:0] snap, int noisy);
      p_kind = kind; p_task = t; p_snap = snap; p_noisy = noisy;
      op_valid_i = 1'b1;
      op_kind_i  = kind[0];
      op_task_i  = t[TW-1:0];
      core_ctx_i = snap;
   endtask

   task automatic op_finish(string req);
      int tgt;
      tgt = pick_target(p_kind, p_task);
      m_ctx[m_cur] = p_snap;
      if (p_kind == 0 && p_task != m_cur) m_link[p_task] = m_cur;
      @(posedge clk);
      @(negedge clk);
      rec_valid_i = 1'b0;
      rec_first_i = 1'b0;
      if (p_noisy != 0) begin
         op_kind_i = 1'b0;
         op_task_i = TW'(tgt ^ 5);
      end else begin
         op_valid_i = 1'b0;
      end
      chk({req, " R2 strobe low"}, 256'(ctx_load_o), 256'(0));
      @(posedge clk);
      @(negedge clk);
      chk({req, " R2 strobe high"}, 256'(ctx_load_o), 256'(1));
      chk({req, " ctx"}, ctx_o, m_ctx[tgt]);
      chk({req, " R2 cur task"}, 256'(cur_task_o), 256'(tgt));
      m_cur = tgt;
      @(posedge clk);
      @(negedge clk);
      op_valid_i = 1'b0;
   endtask

   task automatic do_op(string req, int kind, int t, bit [255:0] snap, int noisy);
      op_start(kind, t, snap, noisy);
      op_finish(req);
   endtask

   task automatic send_rec(int t, bit [255:0] w, int with_op, int ot, bit [255:0] snap);
      for (int k = 0; k < 32; k++) begin
         rec_valid_i = 1'b1;
         rec_first_i = (k == 0);
         rec_task_i  = (k == 0) ? TW'(t) : TW'(t ^ 1);
         rec_byte_i  = w[8*k +: 8];
         if (k == 31) break;
         @(posedge clk);
         @(negedge clk);
      end
      if (with_op != 0) begin
         op_start(0, ot, snap, 0);
         op_finish("R8 overlapped switch");
      end else begin
         @(posedge clk);
         @(negedge clk);
         rec_valid_i = 1'b0;
         rec_first_i = 1'b0;
         @(posedge clk);
         @(negedge clk);
         @(posedge clk);
         @(negedge clk);
      end
      m_ctx[t] = w;
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      bit [255:0] lay;
      int set [9];
      void'($urandom(32'h5eed_0c7a));
      for (int i = 0; i < N; i++) m_link[i] = 0;
      for (int i = 0; i < 8; i++) set[i] = i;
      set[8] = 511;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 cur task", 256'(cur_task_o), 256'(0));
      chk("R1 strobe", 256'(ctx_load_o), 256'(0));

      // R6 layout record for task 3, built byte by byte
      lay = '0;
      lay[31:0]    = 32'h1122_3344;  // code seg, bytes 0-3
      lay[63:32]   = 32'h5566_7788;  // data seg, bytes 4-7
      lay[87:64]   = 24'h0a_bcde;    // pc, bytes 8-10
      lay[119:88]  = 32'hdead_beef;  // acc
      lay[151:120] = 32'h0000_1234;  // x
      lay[183:152] = 32'h0000_5678;  // y
      lay[215:184] = 32'h0000_3fff;  // sp
      lay[223:216] = 8'h24;          // status, byte 27
      lay[231:224] = 8'h02;          // status ext, byte 28
      lay[239:232] = 8'h7e;          // data bank, byte 29
      lay[255:240] = 16'hc0de;       // direct page, bytes 30-31
      for (int i = 0; i < 9; i++)
         send_rec(set[i], (set[i] == 3) ? lay : rnd256(), 0, 0, '0);

      do_op("R6 R3 switch into layout task", 0, 3, rnd256(), 0);
      chk("R6 code seg", 256'(ctx_o[31:0]), 256'(32'h1122_3344));
      chk("R6 pc", 256'(ctx_o[87:64]), 256'(24'h0a_bcde));
      chk("R6 status ext", 256'(ctx_o[231:224]), 256'(8'h02));
      chk("R6 direct page", 256'(ctx_o[255:240]), 256'(16'hc0de));

      do_op("R5 self switch", 0, 3, rnd256(), 0);
      do_op("R4 return to invoker", 1, 0, rnd256(), 0);
      do_op("R9 return from task 0", 1, 0, rnd256(), 0);
      do_op("R7 noisy request", 0, 6, rnd256(), 1);
      do_op("R3 switch back after noise", 0, 2, rnd256(), 0);

      // R8: record into 5 completes on the edge that accepts a switch to 6
      send_rec(5, rnd256(), 1, 6, rnd256());
      do_op("R8 record after overlap", 0, 5, rnd256(), 0);

      for (int n = 0; n < 400; n++) begin
         int r;
         r = int'($urandom_range(0, 9));
         if (r == 0) begin
            int s;
            s = set[$urandom_range(0, 8)];
            if (s != m_cur) send_rec(s, rnd256(), 0, 0, '0);
         end else if (r < 4) begin
            do_op("R4 random return", 1, 0, rnd256(), int'($urandom_range(0, 1)));
         end else begin
            do_op("R3 random switch", 0, set[$urandom_range(0, 8)], rnd256(), int'($urandom_range(0, 1)));
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule